// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial character stream on one input line into parallel bytes for a host. A character is a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The block runs from a receive clock whose rate relates to the bit rate by a selectable factor of 1, 16 or 64. In the two oversampled modes the line passes through a two-flop synchronizer, and a start edge must still be low at the middle of the start bit to count as a start.

A shift stage assembles each character. When the final stop bit is sampled, the character moves into a holding register together with its parity and framing status, and the ready flag goes high. The host takes the byte and acknowledges it with a one-cycle read strobe. If a second character completes while the first one is still unread, the new character is dropped and the overrun flag is raised. The configuration inputs are expected to change only while the line is idle.

Top module: `serial_rx_ovs`

## Requirements
- R1: A synchronous active-high reset clears rx_ready, err_parity, err_frame and err_overrun and sets rx_data to zero. The receiver then waits for a start edge.
- R2: The ratio select cfg_div chooses the mode: 00 gives one clock per bit, 01 gives 16 clocks per bit and 10 or 11 gives 64 clocks per bit. In the oversampled modes the start bit is re-sampled HALF clocks after the clock edge that registers the synchronized falling edge. Each later bit is sampled one full bit period after the previous sample, where HALF is 8 or 32. The synchronizer and the edge register add 2 clocks. So rx_ready rises at clock edge 2 + HALF + FULL * (data + parity + stop bits), counted from the first edge that sees the line low.
- R3: Data arrive least significant bit first. cfg_len8 = 1 selects 8 data bits and 0 selects 7. With 7 bits, rx_data[7] reads 0.
- R4: cfg_par_en = 1 means a parity bit follows the data. With cfg_par_odd = 0, err_parity is set when the data bits and the parity bit together hold an odd number of ones. With cfg_par_odd = 1, it is set when they hold an even number. err_parity is 0 when parity is disabled.
- R5: cfg_two_stop = 1 selects two stop bits and 0 selects one. err_frame is set when any stop bit is sampled low.
- R6: In the oversampled modes, a low pulse that has returned high by the start-bit midpoint delivers no character, and the next real character is received correctly.
- R7: With a ratio of one, rxd is sampled directly on each clock edge with no synchronizer. A start bit is registered on the first edge that sees the line low, and each following bit is taken on the next edge.
- R8: rx_ready, rx_data, err_parity and err_frame all update on the same edge when a character is transferred. A read strobe on rd clears rx_ready.
- R9: If a character completes while rx_ready is 1 and rd is low, err_overrun is set. The new character is discarded, and rx_data and the other flags keep their values.
- R10: err_overrun clears on the first read strobe after it was set.
- R11: If rd is high on the edge where a character completes, the new character is loaded, rx_ready stays 1 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial data line, idle high |
| cfg_div | input | 2 | Clock-per-bit ratio select |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd | input | 1 | Host read strobe, one cycle |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Parity mismatch on held character |
| err_frame | output | 1 | Stop bit sampled low on held character |
| err_overrun | output | 1 | Character lost while holding register full |

## Verification
A sample counter reloaded with the wrong value, or off by one, moves the delivery edge. That shows up as rx_ready rising a clock early or late in the exact-timing checks. In the one-clock-per-bit mode it also shows up within a single frame as shifted data bits. A bit index that mixes up the parity and stop positions shows up as a wrong err_parity or err_frame on the same character. A holding-register policy that is wrong shows up on the second back-to-back character, as changed data or a missing overrun flag.

// File: rtl/serial_rx_ovs.sv
module serial_rx_ovs #(
  parameter int RATE_A = 16,
  parameter int RATE_B = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic [1:0] cfg_div,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       rd,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);

  localparam int CW = $clog2(RATE_B);
  localparam logic [CW-1:0] A_FULL = CW'(RATE_A - 1);
  localparam logic [CW-1:0] A_HALF = CW'(RATE_A / 2 - 1);
  localparam logic [CW-1:0] B_FULL = CW'(RATE_B - 1);
  localparam logic [CW-1:0] B_HALF = CW'(RATE_B / 2 - 1);

  typedef enum logic [1:0] {IDLE, START, BITS} st_t;

  st_t           st;
  logic          s1, s2, line_d;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    sh;
  logic          pbit, ferr;

  wire           direct = (cfg_div == 2'b00);
  wire [CW-1:0]  full   = direct ? '0 : (cfg_div == 2'b01) ? A_FULL : B_FULL;
  wire [CW-1:0]  half   = (cfg_div == 2'b01) ? A_HALF : B_HALF;
  wire           line   = direct ? rxd : s2;
  wire           fall   = line_d & ~line;
  wire           tick   = (cnt == '0);

  wire [3:0]     nd       = cfg_len8 ? 4'd8 : 4'd7;
  wire [3:0]     last_idx = nd + {3'b000, cfg_par_en} + {3'b000, cfg_two_stop};
  wire           sample   = (st == BITS) && tick;
  wire           is_data  = idx < nd;
  wire           is_par   = cfg_par_en && (idx == nd);
  wire           is_stop  = !is_data && !is_par;
  wire           done     = sample && (idx == last_idx);

  wire [7:0]     word   = cfg_len8 ? sh : {1'b0, sh[7:1]};
  wire           perr   = cfg_par_en & (^word ^ pbit ^ cfg_par_odd);
  wire           accept = done & (~rx_ready | rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      line_d <= 1'b1;
    end else begin
      s1     <= rxd;
      s2     <= s1;
      line_d <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      ferr <= 1'b0;
    end else begin
      case (st)
        IDLE: if (fall) begin
          idx  <= '0;
          ferr <= 1'b0;
          if (direct) begin
            st  <= BITS;
            cnt <= '0;
          end else begin
            st  <= START;
            cnt <= half;
          end
        end
        START: if (tick) begin
          if (line) st <= IDLE;
          else begin
            st  <= BITS;
            cnt <= full;
          end
        end else cnt <= cnt - 1'b1;
        BITS: if (tick) begin
          cnt <= full;
          idx <= idx + 1'b1;
          if (is_data) sh <= {line, sh[7:1]};
          if (is_par) pbit <= line;
          if (is_stop && !line) ferr <= 1'b1;
          if (done) st <= IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (rd) begin
        rx_ready    <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (accept) begin
        rx_data    <= word;
        rx_ready   <= 1'b1;
        err_parity <= perr;
        err_frame  <= ferr | ~line;
      end else if (done) begin
        err_overrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_rx_ovs_chk.sv
module serial_rx_ovs_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd,
  input logic       done,
  input logic       cfg_len8,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !rx_ready && !err_parity && !err_frame && !err_overrun); // R1

  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    rd && !done |=> !rx_ready); // R8

  AST_OVERRUN_NEEDS_UNREAD: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(rx_ready) && !$past(rd)); // R9

  AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    rx_ready && !rd |=> rx_ready && $stable(rx_data)); // R9

  AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    err_overrun && rd |=> !err_overrun); // R10

  AST_SAME_CYCLE_READ: assert property (@(posedge clk) disable iff (rst)
    done && rd |=> rx_ready && !err_overrun); // R11

  AST_SEVEN_BIT_TOP: assert property (@(posedge clk) disable iff (rst)
    done && !cfg_len8 && (!rx_ready || rd) |=> !rx_data[7]); // R3

endmodule

bind serial_rx_ovs serial_rx_ovs_chk u_chk (
  .clk(clk), .rst(rst), .rd(rd), .done(done), .cfg_len8(cfg_len8),
  .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/serial_rx_ovs_test.sv
module serial_rx_ovs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] div = 2'b00;
  logic       len8 = 1'b1, pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_rx_ovs uut (
    .clk(clk), .rst(rst), .rxd(rxd), .cfg_div(div), .cfg_len8(len8),
    .cfg_par_en(pen), .cfg_par_odd(podd), .cfg_two_stop(two), .rd(rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // e: 0 clean, 1 flipped parity, 2 first stop low, 3 second stop low
  task automatic send(input logic [7:0] d, input int e, input int bl);
    int nd;
    logic [7:0] dm;
    logic p;
    nd = len8 ? 8 : 7;
    dm = len8 ? d : (d & 8'h7f);
    p = (^dm) ^ podd ^ (e == 1);
    rxd = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd = d[i];
      repeat (bl) @(negedge clk);
    end
    if (pen) begin
      rxd = p;
      repeat (bl) @(negedge clk);
    end
    rxd = (e == 2) ? 1'b0 : 1'b1;
    repeat (bl) @(negedge clk);
    if (two) begin
      rxd = (e == 3) ? 1'b0 : 1'b1;
      repeat (bl) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * bl + 2) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic expect_char(input logic [7:0] d, input int e, input string tag);
    check("R8", {tag, " ready"}, int'(rx_ready), 1);
    check("R3", {tag, " data"}, int'(rx_data), int'(len8 ? d : (d & 8'h7f)));
    check("R4", {tag, " parity flag"}, int'(err_parity), int'(pen && e == 1));
    check("R5", {tag, " frame flag"}, int'(err_frame), int'(e == 2 || (e == 3 && two)));
    check("R9", {tag, " no overrun"}, int'(err_overrun), 0);
    read_pulse();
    check("R8", {tag, " ready cleared by read"}, int'(rx_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] a, b;
    int e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "ready after reset", int'(rx_ready), 0);
    check("R1", "data after reset", int'(rx_data), 0);
    check("R1", "flags after reset", int'({err_parity, err_frame, err_overrun}), 0);

    // R7: direct sampling, full sweep of framing options and byte values
    div = 2'b00;
    for (int c = 0; c < 16; c++) begin
      len8 = c[0]; pen = c[1]; podd = c[2]; two = c[3];
      for (int d = 0; d < 256; d++) begin
        e = (d + c) % 4;
        send(8'(d), e, 1);
        expect_char(8'(d), e, "R7 direct");
      end
    end

    // R11: read strobe on the completing edge (8 data, no parity, one stop)
    len8 = 1'b1; pen = 1'b0; podd = 1'b0; two = 1'b0;
    a = 8'h3c; b = 8'hc5;
    send(a, 0, 1);
    fork
      send(b, 0, 1);
      begin
        repeat (9) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end
    join
    check("R11", "ready kept", int'(rx_ready), 1);
    check("R11", "new data loaded", int'(rx_data), int'(b));
    check("R11", "no overrun", int'(err_overrun), 0);
    read_pulse();

    // R2: exact delivery edge at 16 clocks per bit
    div = 2'b01;
    fork
      send(8'ha7, 0, 16);
      begin
        repeat (154) @(negedge clk);
        check("R2", "x16 not ready at edge 153", int'(rx_ready), 0);
        @(negedge clk);
        check("R2", "x16 ready at edge 154", int'(rx_ready), 1);
      end
    join
    check("R2", "x16 data", int'(rx_data), 8'ha7);
    read_pulse();

    // R3 R4 R5 at 16 clocks per bit
    for (int c = 0; c < 16; c += 5) begin
      len8 = c[0]; pen = c[1]; podd = c[2]; two = c[3];
      for (int k = 0; k < 4; k++) begin
        a = 8'(k * 73 + 17);
        send(a, k, 16);
        expect_char(a, k, "R2 x16");
      end
    end

    // R6: false start is ignored
    len8 = 1'b1; pen = 1'b1; podd = 1'b1; two = 1'b0;
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R6", "no character from glitch", int'(rx_ready), 0);
    send(8'h5e, 0, 16);
    expect_char(8'h5e, 0, "R6 after glitch");

    // R9 R10: overrun keeps first character and its flags
    pen = 1'b0; podd = 1'b0;
    send(8'h11, 0, 16);
    send(8'hee, 2, 16);
    check("R9", "ready held", int'(rx_ready), 1);
    check("R9", "first data kept", int'(rx_data), 8'h11);
    check("R9", "overrun set", int'(err_overrun), 1);
    check("R9", "frame flag of first kept", int'(err_frame), 0);
    read_pulse();
    check("R10", "overrun cleared by read", int'(err_overrun), 0);
    check("R8", "ready cleared after overrun", int'(rx_ready), 0);

    // R2: 64 clocks per bit, exact edge, both select codes
    div = 2'b10;
    fork
      send(8'h96, 0, 64);
      begin
        repeat (610) @(negedge clk);
        check("R2", "x64 not ready at edge 609", int'(rx_ready), 0);
        @(negedge clk);
        check("R2", "x64 ready at edge 610", int'(rx_ready), 1);
      end
    join
    check("R2", "x64 data", int'(rx_data), 8'h96);
    read_pulse();
    div = 2'b11;
    len8 = 1'b0; pen = 1'b1; two = 1'b1;
    send(8'hff, 1, 64);
    expect_char(8'hff, 1, "R2 x64 code 11");

    // R1: reset while a character is held
    div = 2'b00; len8 = 1'b1; pen = 1'b0; two = 1'b0;
    send(8'h42, 0, 1);
    send(8'h24, 0, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "ready after mid-run reset", int'(rx_ready), 0);
    check("R1", "flags after mid-run reset", int'({err_parity, err_frame, err_overrun}), 0);
    check("R1", "data after mid-run reset", int'(rx_data), 0);

    finish_run();
  end
endmodule